// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block is the synchronous control core of a half-bridge gate driver. It takes a PWM command, an enable, a rectifier-mode select and an active-low clamp request. It also reads two sensed feedback bits: the level of the low-side gate and the level of the switch node. From these it produces on-commands for the high-side and low-side gates. A gate is switched on only after the feedback shows that the opposite switch has really turned off. A minimum count of idle clock cycles must also pass first, so a glitch on the feedback cannot cause an early turn-on.

Every input crosses into the clock domain through a two-flop synchronizer. A build-time parameter selects whether the command is read inverted or as-is. A timeout runs in each wait phase. If the feedback never confirms, both gates are held off and a sticky fault is raised. The fault clears only when the enable drops. The clamp request overrides everything else and turns the low-side switch on to short the output. On release, the controller leaves the clamp through the low-side-on state and resumes normal arbitration from there.

Top module: `dtgate_top`

## Requirements
- R1: While the synchronized clamp request (`clamp_n_i` = 0) is active, the low-side output is on and the high-side output is off, whatever the enable, mode, command, feedback or fault state.
- R2: With no clamp active, a low enable drives both outputs off and clears the fault flag.
- R3: With `rect_en_i` = 0 (non-synchronous mode), the low-side output stays off, except in the clamp state and the single low-side-on state that follows it. The high-side output still follows the command.
- R4: The high-side output turns on only when the synchronized low-side gate feedback `lsg_fb_i` reads 0.
- R5: The low-side output turns on from normal arbitration only when the synchronized switch-node feedback `sw_fb_i` reads 0.
- R6: Before either output turns on from a wait phase, both outputs stay off for at least `MIN_DT` clock cycles.
- R7: With `CMD_INVERT` = 1, a 0 on `cmd_i` selects the high side and a 1 selects the low side (or neither when `rect_en_i` = 0). With `CMD_INVERT` = 0, the mapping is the reverse.
- R8: Each input passes through two synchronizer flops, and the state register follows them. An input change is therefore seen at the outputs right after the third rising edge. A command change switches off the active gate at that same edge.
- R9: If the feedback has not confirmed after `WAIT_LIMIT` cycles in a wait phase, `fault_o` goes to 1 and both outputs stay off until the enable goes low.
- R10: Under reset, both outputs and `fault_o` are 0 and the controller is idle.
- R11: When the clamp is released, the low-side output stays on for one more cycle and then normal arbitration resumes. The high side never turns on directly from the clamp.
- R12: The high-side and low-side outputs are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 1 | PWM command, polarity set by `CMD_INVERT` |
| en_i | input | 1 | Enable. Low forces both gates off and clears the fault |
| rect_en_i | input | 1 | 1 = synchronous rectification, 0 = low side kept off |
| clamp_n_i | input | 1 | Active-low clamp request, forces the low side on |
| lsg_fb_i | input | 1 | Sensed low-side gate level (1 = gate high) |
| sw_fb_i | input | 1 | Sensed switch-node level (1 = node high) |
| hs_on_o | output | 1 | High-side gate on-command |
| ls_on_o | output | 1 | Low-side gate on-command |
| fault_o | output | 1 | Sticky feedback-timeout fault |

## Verification
Some of these functions can fall in the same cycle. A clamp request can arrive on the edge where a wait phase would confirm or time out. A feedback confirmation can land on the very cycle the timeout expires. The random stimulus makes both happen often: it mixes short clamp pulses, enable drops and biased feedback noise, and uses a short timeout limit. A cycle-accurate reference model in the bench judges the result at every cycle, with the clamp ranked above the enable, the enable above the fault, and a confirmation ranked above an expiry.

// File: rtl/dtgate_pkg.sv
package dtgate_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_HS_WAIT = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_LS_WAIT = 3'd3,
        ST_LS_ON   = 3'd4,
        ST_CLAMP   = 3'd5
    } gate_state_t;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HI   = 2'd1,
        SIDE_LO   = 2'd2
    } side_t;

    typedef struct packed {
        logic clamp_n;
        logic en;
        logic rect;
        logic drive;
        logic lsg_fb;
        logic sw_fb;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam ctl_t CTL_IDLE = '{clamp_n: 1'b1, en: 1'b0, rect: 1'b0,
                                  drive: 1'b0, lsg_fb: 1'b0, sw_fb: 1'b0};

    function automatic side_t pick_side(input ctl_t c);
        if (c.drive)
            return SIDE_HI;
        else if (c.rect)
            return SIDE_LO;
        else
            return SIDE_NONE;
    endfunction

    function automatic logic is_wait(input gate_state_t s);
        return (s == ST_HS_WAIT) || (s == ST_LS_WAIT);
    endfunction

endpackage

// File: rtl/dtgate_sync.sv
module dtgate_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg_q[i] <= RST_VAL;
                else     stg_q[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg_q[i] <= RST_VAL;
                else     stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dtgate_wait_timer.sv
module dtgate_wait_timer #(
    parameter int MIN_DT     = 4,
    parameter int WAIT_LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    output logic dt_done_o,
    output logic expired_o
);
    localparam int CW      = $clog2(WAIT_LIMIT + 1);
    localparam logic [CW-1:0] DT_LAST  = CW'(MIN_DT - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(WAIT_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !hold_i)
            cnt_q <= '0;
        else if (cnt_q != TMO_LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign dt_done_o = (cnt_q >= DT_LAST);
    assign expired_o = (cnt_q >= TMO_LAST);

    AST_EXPIRE_AFTER_DT: assert property (@(posedge clk) disable iff (rst)
        expired_o |-> dt_done_o) else $error("expiry before dead time"); // R6
endmodule

// File: rtl/dtgate_fsm.sv
module dtgate_fsm
    import dtgate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    input  logic dt_done_i,
    input  logic expired_i,
    output logic hold_o,
    output logic hs_on_o,
    output logic ls_on_o,
    output logic fault_o
);
    gate_state_t state_q, state_d;
    logic        fault_q, fault_d;
    side_t       side;

    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        side    = pick_side(ctl_i);
        if (!ctl_i.clamp_n) begin
            state_d = ST_CLAMP;
        end else if (state_q == ST_CLAMP) begin
            state_d = ST_LS_ON;
        end else if (!ctl_i.en) begin
            state_d = ST_OFF;
            fault_d = 1'b0;
        end else if (fault_q) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_HS_WAIT: begin
                    if (side == SIDE_HI) begin
                        if (dt_done_i && !ctl_i.lsg_fb) begin
                            state_d = ST_HS_ON;
                        end else if (expired_i) begin
                            state_d = ST_OFF;
                            fault_d = 1'b1;
                        end
                    end else if (side == SIDE_LO) begin
                        state_d = ST_LS_WAIT;
                    end else begin
                        state_d = ST_OFF;
                    end
                end
                ST_LS_WAIT: begin
                    if (side == SIDE_LO) begin
                        if (dt_done_i && !ctl_i.sw_fb) begin
                            state_d = ST_LS_ON;
                        end else if (expired_i) begin
                            state_d = ST_OFF;
                            fault_d = 1'b1;
                        end
                    end else if (side == SIDE_HI) begin
                        state_d = ST_HS_WAIT;
                    end else begin
                        state_d = ST_OFF;
                    end
                end
                ST_OFF, ST_HS_ON, ST_LS_ON: begin
                    if (side == SIDE_HI)
                        state_d = (state_q == ST_HS_ON) ? ST_HS_ON : ST_HS_WAIT;
                    else if (side == SIDE_LO)
                        state_d = (state_q == ST_LS_ON) ? ST_LS_ON : ST_LS_WAIT;
                    else
                        state_d = ST_OFF;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    assign hold_o  = is_wait(state_q) && (state_d == state_q);
    assign hs_on_o = (state_q == ST_HS_ON);
    assign ls_on_o = (state_q == ST_LS_ON) || (state_q == ST_CLAMP);
    assign fault_o = fault_q;

    AST_CLAMP_FORCES_LS: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.clamp_n |=> (ls_on_o && !hs_on_o)) else $error("clamp ignored"); // R1
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.clamp_n && !ctl_i.en && state_q != ST_CLAMP) |=> (!hs_on_o && !ls_on_o && !fault_o))
        else $error("disable not honoured"); // R2
    AST_NONSYNC_LS_OFF: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.clamp_n && !ctl_i.rect && state_q != ST_CLAMP) |=> !ls_on_o)
        else $error("low side on in non-sync mode"); // R3
    AST_HS_AFTER_LSG_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_on_o) |-> $past(!ctl_i.lsg_fb)) else $error("high side early"); // R4
    AST_LS_AFTER_SW_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(ls_on_o) && state_q == ST_LS_ON) |-> $past(!ctl_i.sw_fb))
        else $error("low side early"); // R5
    AST_MIN_DEADTIME: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_on_o) || ($rose(ls_on_o) && state_q == ST_LS_ON)) |-> $past(dt_done_i))
        else $error("dead time cut short"); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fault_o && ctl_i.en) |=> fault_o) else $error("fault lost"); // R9
    AST_FAULT_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> (!hs_on_o && !ls_on_o)) else $error("gate on at fault"); // R9
    AST_CLAMP_EXIT_LS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLAMP && ctl_i.clamp_n) |=> (ls_on_o && !hs_on_o))
        else $error("bad clamp exit"); // R11
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hs_on_o && ls_on_o)) else $error("shoot-through"); // R12
endmodule

// File: rtl/dtgate_top.sv
module dtgate_top
    import dtgate_pkg::*;
#(
    parameter bit CMD_INVERT = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_DT      = 4,
    parameter int WAIT_LIMIT  = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_i,
    input  logic en_i,
    input  logic rect_en_i,
    input  logic clamp_n_i,
    input  logic lsg_fb_i,
    input  logic sw_fb_i,
    output logic hs_on_o,
    output logic ls_on_o,
    output logic fault_o
);
    ctl_t raw_c, syn_c, ctl_c;
    logic dt_done, expired, hold;

    assign raw_c = '{clamp_n: clamp_n_i, en: en_i, rect: rect_en_i,
                     drive: cmd_i, lsg_fb: lsg_fb_i, sw_fb: sw_fb_i};

    dtgate_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_c),
        .q_o (syn_c)
    );

    if (CMD_INVERT) begin : g_cmd_inv
        always_comb begin
            ctl_c       = syn_c;
            ctl_c.drive = ~syn_c.drive;
        end
    end else begin : g_cmd_pass
        always_comb ctl_c = syn_c;
    end

    dtgate_wait_timer #(
        .MIN_DT     (MIN_DT),
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold),
        .dt_done_o (dt_done),
        .expired_o (expired)
    );

    dtgate_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl_c),
        .dt_done_i (dt_done),
        .expired_i (expired),
        .hold_o    (hold),
        .hs_on_o   (hs_on_o),
        .ls_on_o   (ls_on_o),
        .fault_o   (fault_o)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!hs_on_o && !ls_on_o && !fault_o)) else $error("reset state"); // R10
endmodule

// File: tb/sim_dtgate_top.sv
module sim_dtgate_top;
    localparam bit INV = 1'b1;
    localparam int MD  = 3;
    localparam int WL  = 12;
    localparam int S_OFF = 0, S_HSW = 1, S_HSON = 2, S_LSW = 3, S_LSON = 4, S_CL = 5;

    logic clk = 1'b0;
    logic rst, cmd, en, rect, clamp_n, lfb, swfb;
    logic hs, ls, flt;
    int   checks = 0, errors = 0, cyc = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    dtgate_top #(.CMD_INVERT(INV), .SYNC_STAGES(2), .MIN_DT(MD), .WAIT_LIMIT(WL)) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd), .en_i(en), .rect_en_i(rect),
        .clamp_n_i(clamp_n), .lsg_fb_i(lfb), .sw_fb_i(swfb),
        .hs_on_o(hs), .ls_on_o(ls), .fault_o(flt));

    // reference model: bits {clamp_n, en, rect, cmd, lfb, swfb}
    logic [5:0] p1, p2;
    int  ms, mc, ns, side;
    bit  mf, nf;

    always @(posedge clk) begin
        if (rst) begin
            p1 <= 6'b100000; p2 <= 6'b100000; ms <= S_OFF; mc <= 0; mf <= 1'b0;
        end else begin
            ns = ms; nf = mf;
            side = (p2[2] ^ INV) ? 1 : (p2[3] ? 2 : 0);
            if (!p2[5]) ns = S_CL;
            else if (ms == S_CL) ns = S_LSON;
            else if (!p2[4]) begin ns = S_OFF; nf = 1'b0; end
            else if (mf) ns = S_OFF;
            else if (ms == S_HSW) begin
                if (side == 1) begin
                    if (mc >= MD-1 && !p2[1]) ns = S_HSON;
                    else if (mc >= WL-1) begin ns = S_OFF; nf = 1'b1; end
                end else ns = (side == 2) ? S_LSW : S_OFF;
            end else if (ms == S_LSW) begin
                if (side == 2) begin
                    if (mc >= MD-1 && !p2[0]) ns = S_LSON;
                    else if (mc >= WL-1) begin ns = S_OFF; nf = 1'b1; end
                end else ns = (side == 1) ? S_HSW : S_OFF;
            end else begin
                if (side == 1) ns = (ms == S_HSON) ? S_HSON : S_HSW;
                else if (side == 2) ns = (ms == S_LSON) ? S_LSON : S_LSW;
                else ns = S_OFF;
            end
            mc <= (ns == ms && (ms == S_HSW || ms == S_LSW)) ? ((mc == WL-1) ? mc : mc + 1) : 0;
            ms <= ns; mf <= nf;
            p1 <= {clamp_n, en, rect, cmd, lfb, swfb}; p2 <= p1;
        end
    end

    function automatic string tag_of(int s, bit f, logic [5:0] p);
        if (s == S_CL) return "R1";
        if (f) return "R9";
        if (!p[4]) return "R2";
        if (s == S_HSON) return "R4";
        if (s == S_LSON) return "R5";
        if (s == S_HSW || s == S_LSW) return "R6";
        return "R8";
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, plus the R12 overlap rule
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tag_of(ms, mf, p2), "hs_on", hs, (ms == S_HSON));
            chk(tag_of(ms, mf, p2), "ls_on", ls, (ms == S_LSON || ms == S_CL));
            chk(tag_of(ms, mf, p2), "fault", flt, mf);
            chk("R12", "overlap", hs & ls, 1'b0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            errors++; checks++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic adv(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1977));
        rst = 1'b1; clamp_n = 1'b1; en = 1'b0; rect = 1'b0; cmd = 1'b1; lfb = 1'b0; swfb = 1'b0;
        adv(4);
        rst = 1'b0;
        adv(1);
        chk("R10", "hs after reset", hs, 1'b0);
        chk("R10", "ls after reset", ls, 1'b0);
        chk("R10", "fault after reset", flt, 1'b0);

        // R7 R6 R4: inverted command 0 selects high side after MD idle cycles
        en = 1'b1; rect = 1'b0; cmd = 1'b1;
        adv(8);
        cmd = 1'b0;
        adv(2 + MD);
        chk("R6", "hs still off in dead time", hs, 1'b0);
        adv(1);
        chk("R7", "hs on for inverted low command", hs, 1'b1);

        // R8 R1: clamp seen after the third edge
        clamp_n = 1'b0;
        adv(2);
        chk("R8", "hs before clamp reaches state", hs, 1'b1);
        adv(1);
        chk("R1", "ls forced by clamp", ls, 1'b1);
        chk("R1", "hs dropped by clamp", hs, 1'b0);

        // R11: clamp exit goes through low-side-on
        clamp_n = 1'b1;
        adv(3);
        chk("R11", "ls held on exit", ls, 1'b1);
        chk("R11", "hs off on exit", hs, 1'b0);
        adv(1);
        chk("R11", "ls off after exit", ls, 1'b0);
        chk("R11", "hs not direct after exit", hs, 1'b0);
        adv(10);

        // R3: non-sync mode, low command selects nothing
        rect = 1'b0; cmd = 1'b1;
        adv(12);
        chk("R3", "ls stays off non-sync", ls, 1'b0);
        chk("R3", "hs off non-sync idle", hs, 1'b0);
        cmd = 1'b0;
        adv(3 + MD);
        chk("R3", "hs follows command non-sync", hs, 1'b1);

        // R9: stuck gate feedback times out
        cmd = 1'b1;
        adv(6);
        lfb = 1'b1; cmd = 1'b0;
        adv(2 + WL);
        chk("R9", "fault before limit", flt, 1'b0);
        adv(1);
        chk("R9", "fault at limit", flt, 1'b1);
        chk("R9", "hs off at fault", hs, 1'b0);
        lfb = 1'b0;
        adv(10);
        chk("R9", "hs held off after fault", hs, 1'b0);
        chk("R9", "fault sticky", flt, 1'b1);
        en = 1'b0;
        adv(3);
        chk("R2", "fault cleared by enable low", flt, 1'b0);
        chk("R2", "both off when disabled", hs | ls, 1'b0);

        // R5: low side waits for switch node low
        en = 1'b1; rect = 1'b1; cmd = 1'b1; swfb = 1'b1;
        adv(3 + MD + 4);
        chk("R5", "ls off while node high", ls, 1'b0);
        swfb = 1'b0;
        adv(3);
        chk("R5", "ls on after node low", ls, 1'b1);

        // random mix: clamp pulses, enable drops, feedback noise
        for (int i = 0; i < 5000; i++) begin
            clamp_n = ($urandom % 60) != 0;
            if ($urandom % 40 == 0) en = ~en;
            if (!en && ($urandom % 4 == 0)) en = 1'b1;
            if ($urandom % 50 == 0) rect = ~rect;
            if ($urandom % 10 == 0) cmd = ~cmd;
            lfb  = ($urandom % 10) < 3;
            swfb = ($urandom % 10) < 3;
            adv(1);
        end

        // stuck feedback bursts for repeated timeouts
        en = 1'b1; rect = 1'b1; clamp_n = 1'b1;
        for (int i = 0; i < 600; i++) begin
            lfb = 1'b1; swfb = 1'b1;
            if (i % 25 == 0) cmd = ~cmd;
            en = (i % 100) > 3;
            adv(1);
        end

        adv(5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule